// File: doc/BRIEF.md
# Serial Receiver with Sticky Parity Error

This block turns an asynchronous serial line into characters. It uses the same character length, parity-enable and parity-polarity settings as the matching transmitter. A free-running tick at sixteen times the bit rate paces the receiver. Each bit is sampled once, at the centre of its bit time, and the character is presented on a parallel output together with a one-cycle valid strobe.

When parity is on, the most significant received bit is the parity bit. The block checks it against the bits below it. A mismatch sets a sticky error flag, and that flag drives an interrupt when the enable input is high. Software clears the flag with a two-step handshake: a status-read strobe, then a data-access strobe.

An optional address-wakeup mode marks characters whose top data bit is 1 as address characters, and those are exempt from the parity check. A mute request puts the receiver to sleep. While asleep it discards data characters and wakes on the first address character, which it delivers.

Top module: `uart_rx_parity`

## Requirements
- R1: After reset, `rx_valid_o`, `pe_o` and `irq_o` are 0 and `rx_data_o` is all zeros.
- R2: A character starts on the first tick that sees `rx_i` low. Each bit, start bit included, lasts 16 ticks and is sampled on the 8th tick of its slot. Data arrives LSB first. There are 8 bits when `len9_i`=0 and 9 bits when `len9_i`=1. The stop bit is sampled but not judged. A completed character gives a one-cycle `rx_valid_o` pulse, and `rx_data_o` holds the character from that pulse onward.
- R3: If `rx_i` is high again at the mid-point of the start bit, the start is dropped and no character is delivered.
- R4: With `par_en_i`=1, the top received bit (bit 7 when `len9_i`=0, bit 8 when `len9_i`=1) is the parity bit. A parity error is declared when the count of ones across all received bits is odd while `par_odd_i`=0, or even while `par_odd_i`=1. A parity error sets `pe_o` on the same edge as the `rx_valid_o` pulse.
- R5: With `par_en_i`=1, the parity position of `rx_data_o` reads as 0. With `par_en_i`=0, every received bit is delivered and `pe_o` is never set. Bit positions above the character length read as 0.
- R6: `pe_o` stays set until it is cleared by the sequence in R7. `irq_o` is high exactly while `pe_o` and `pe_ie_i` are both 1.
- R7: `pe_o` is cleared by a `data_acc_i` pulse that comes after a `stat_rd_i` pulse, in the same or any later cycle. A `data_acc_i` pulse with no earlier status read leaves the flag set and cancels any pending read. A status read and a data access in the same cycle arm a new sequence.
- R8: A new parity error wins over a clear in the same cycle. It also cancels any status read already pending, so a later data access alone does not clear it.
- R9: With `addr_wake_i`=1, a character whose top data bit is 1 is an address character. That bit is bit 6 or 7 with parity on, and bit 7 or 8 with parity off, for `len9_i`=0 or 1 respectively. An address character never sets `pe_o`.
- R10: A `mute_req_i` pulse while `addr_wake_i`=1 mutes the receiver. While muted, non-address characters give no `rx_valid_o` and never set `pe_o`. The first address character unmutes the receiver and is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| len9_i | input | 1 | Character length: 0 = 8 bits, 1 = 9 bits |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 0 = even total of ones, 1 = odd total |
| addr_wake_i | input | 1 | Address-mark wakeup mode enable |
| mute_req_i | input | 1 | Pulse: enter mute state |
| stat_rd_i | input | 1 | Pulse: status register was read |
| data_acc_i | input | 1 | Pulse: data register was read or written |
| pe_ie_i | input | 1 | Parity interrupt enable |
| rx_data_o | output | FRAME_MAX_BITS | Received character, parity position masked |
| rx_valid_o | output | 1 | One-cycle pulse: new character on rx_data_o |
| pe_o | output | 1 | Sticky parity error flag |
| irq_o | output | 1 | Parity interrupt request |

## Verification
The assertions check, on every cycle, the parts that are local in time. They confirm that the valid strobe lasts one cycle and that the parity position reads 0. They confirm that the error flag rises only together with a delivered, non-address character. They also confirm that the flag cannot fall without a data access and that the interrupt follows the flag and its enable.

Other behaviour depends on order and history, so only the bench scenarios can show it. This covers mid-bit sampling, glitch rejection on the start bit, and the ordering of the clear handshake (read then access, access alone, and a new error cancelling a pending read). It also covers muting and waking on an address mark. The bench's behavioural model is compared with the outputs on every clock.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int unsigned OSR_DEFAULT      = 16;
    localparam int unsigned FRAME_BITS_DFLT  = 9;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    // Result of evaluating one completed character
    typedef struct packed {
        logic par_err;
        logic is_addr;
    } char_eval_t;

    // Next value of a wrapping oversample counter
    function automatic logic [7:0] wrap_inc(input logic [7:0] v, input logic [7:0] last);
        return (v == last) ? 8'd0 : v + 8'd1;
    endfunction

endpackage

// File: rtl/urx_bit_engine.sv
module urx_bit_engine
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR   = OSR_DEFAULT,
    parameter int unsigned MAXB  = FRAME_BITS_DFLT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_i,
    input  logic            rx_i,
    input  logic            len9_i,
    output logic            done_o,
    output logic [MAXB-1:0] bits_o
);
    localparam int unsigned CW = $clog2(OSR);
    localparam int unsigned IW = $clog2(MAXB);
    localparam logic [7:0]  MID_PT  = 8'(OSR / 2 - 1);
    localparam logic [7:0]  LAST_PT = 8'(OSR - 1);

    rx_state_e       state_q;
    logic [CW-1:0]   cnt_q;
    logic [IW-1:0]   idx_q;
    logic [MAXB-1:0] shift_q;
    logic [IW-1:0]   last_idx;
    logic            at_mid;
    logic            at_end;
    logic [CW-1:0]   cnt_nxt;

    assign last_idx = len9_i ? IW'(MAXB - 1) : IW'(MAXB - 2);
    assign at_mid   = (8'(cnt_q) == MID_PT);
    assign at_end   = (8'(cnt_q) == LAST_PT);
    assign cnt_nxt  = CW'(wrap_inc(8'(cnt_q), LAST_PT));
    assign bits_o   = shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) begin
                unique case (state_q)
                    RX_IDLE: begin
                        if (!rx_i) begin
                            state_q <= RX_START;
                            cnt_q   <= CW'(1);
                        end
                    end
                    RX_START: begin
                        if (at_mid && rx_i) begin
                            state_q <= RX_IDLE;
                        end else begin
                            cnt_q <= cnt_nxt;
                            if (at_end) begin
                                state_q <= RX_DATA;
                                idx_q   <= '0;
                                shift_q <= '0;
                            end
                        end
                    end
                    RX_DATA: begin
                        if (at_mid) shift_q[idx_q] <= rx_i;
                        cnt_q <= cnt_nxt;
                        if (at_end) begin
                            if (idx_q == last_idx) state_q <= RX_STOP;
                            else                   idx_q   <= idx_q + IW'(1);
                        end
                    end
                    RX_STOP: begin
                        if (at_mid) begin
                            state_q <= RX_IDLE;
                            done_o  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_nxt;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/urx_char_eval.sv
module urx_char_eval
    import uart_rx_pkg::*;
#(
    parameter int unsigned MAXB = FRAME_BITS_DFLT
) (
    input  logic [MAXB-1:0] bits_i,
    input  logic            len9_i,
    input  logic            par_en_i,
    input  logic            par_odd_i,
    input  logic            addr_wake_i,
    output logic [MAXB-1:0] data_o,
    output char_eval_t      eval_o
);
    localparam int unsigned IW = $clog2(MAXB);

    logic [MAXB-1:0] in_len;
    logic [MAXB-1:0] is_par;
    logic [IW-1:0]   top_pos;
    logic [IW-1:0]   addr_pos;

    for (genvar i = 0; i < MAXB; i++) begin : g_bit
        assign in_len[i] = (i < MAXB - 1) ? 1'b1 : len9_i;
        assign is_par[i] = par_en_i &&
                           ((len9_i && (i == MAXB - 1)) || (!len9_i && (i == MAXB - 2)));
        assign data_o[i] = bits_i[i] & in_len[i] & ~is_par[i];
    end

    assign top_pos  = len9_i ? IW'(MAXB - 1) : IW'(MAXB - 2);
    assign addr_pos = par_en_i ? top_pos - IW'(1) : top_pos;

    always_comb begin
        eval_o.par_err = (^(bits_i & in_len)) ^ par_odd_i;
        eval_o.is_addr = addr_wake_i & bits_i[addr_pos];
    end

endmodule

// File: rtl/urx_pe_flag.sv
module urx_pe_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic stat_rd_i,
    input  logic data_acc_i,
    output logic pe_o
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pe_o    <= 1'b0;
            armed_q <= 1'b0;
        end else if (set_i) begin
            pe_o    <= 1'b1;
            armed_q <= 1'b0;
        end else begin
            if (data_acc_i && armed_q) pe_o <= 1'b0;
            if (stat_rd_i)             armed_q <= 1'b1;
            else if (data_acc_i)       armed_q <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR            = OSR_DEFAULT,
    parameter int unsigned FRAME_MAX_BITS = FRAME_BITS_DFLT
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rx_i,
    input  logic                      tick16_i,
    input  logic                      len9_i,
    input  logic                      par_en_i,
    input  logic                      par_odd_i,
    input  logic                      addr_wake_i,
    input  logic                      mute_req_i,
    input  logic                      stat_rd_i,
    input  logic                      data_acc_i,
    input  logic                      pe_ie_i,
    output logic [FRAME_MAX_BITS-1:0] rx_data_o,
    output logic                      rx_valid_o,
    output logic                      pe_o,
    output logic                      irq_o
);
    logic                      done;
    logic [FRAME_MAX_BITS-1:0] raw_bits;
    logic [FRAME_MAX_BITS-1:0] clean_data;
    char_eval_t                ev;
    logic                      muted_q;
    logic                      accept;
    logic                      pe_set;

    urx_bit_engine #(.OSR(OSR), .MAXB(FRAME_MAX_BITS)) u_engine (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick16_i),
        .rx_i   (rx_i),
        .len9_i (len9_i),
        .done_o (done),
        .bits_o (raw_bits)
    );

    urx_char_eval #(.MAXB(FRAME_MAX_BITS)) u_eval (
        .bits_i      (raw_bits),
        .len9_i      (len9_i),
        .par_en_i    (par_en_i),
        .par_odd_i   (par_odd_i),
        .addr_wake_i (addr_wake_i),
        .data_o      (clean_data),
        .eval_o      (ev)
    );

    assign accept = done && (!muted_q || ev.is_addr);
    assign pe_set = done && !muted_q && par_en_i && ev.par_err && !ev.is_addr;

    urx_pe_flag u_flag (
        .clk        (clk),
        .rst        (rst),
        .set_i      (pe_set),
        .stat_rd_i  (stat_rd_i),
        .data_acc_i (data_acc_i),
        .pe_o       (pe_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
            muted_q    <= 1'b0;
        end else begin
            rx_valid_o <= accept;
            if (accept) rx_data_o <= clean_data;
            if (mute_req_i && addr_wake_i)      muted_q <= 1'b1;
            else if (done && ev.is_addr)        muted_q <= 1'b0;
        end
    end

    assign irq_o = pe_o & pe_ie_i;

endmodule

// File: rtl/uart_rx_parity_checks.sv
module uart_rx_parity_checks #(
    parameter int unsigned FRAME_MAX_BITS = 9
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      len9_i,
    input logic                      par_en_i,
    input logic                      addr_wake_i,
    input logic                      data_acc_i,
    input logic                      pe_ie_i,
    input logic [FRAME_MAX_BITS-1:0] rx_data_o,
    input logic                      rx_valid_o,
    input logic                      pe_o,
    input logic                      irq_o
);
    logic par_bit_out;
    logic addr_bit_out;

    assign par_bit_out  = len9_i ? rx_data_o[FRAME_MAX_BITS-1] : rx_data_o[FRAME_MAX_BITS-2];
    assign addr_bit_out = par_en_i
        ? (len9_i ? rx_data_o[FRAME_MAX_BITS-2] : rx_data_o[FRAME_MAX_BITS-3])
        : par_bit_out;

    // R2: the valid strobe lasts a single cycle
    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    // R5: parity position is masked in delivered data
    a_r5_par_masked: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o && par_en_i) |-> !par_bit_out);

    // R4: the flag rises only along with a delivered character
    a_r4_rise_with_char: assert property (@(posedge clk) disable iff (rst)
        $rose(pe_o) |-> rx_valid_o);

    // R9: an address character never raises the flag
    a_r9_addr_exempt: assert property (@(posedge clk) disable iff (rst)
        $rose(pe_o) |-> !(addr_wake_i && addr_bit_out));

    // R7: the flag can only fall after a data access
    a_r7_fall_needs_access: assert property (@(posedge clk) disable iff (rst)
        $fell(pe_o) |-> $past(data_acc_i));

    // R6: flag holds without a data access
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (pe_o && !data_acc_i) |=> pe_o);

    // R6: interrupt tracks flag and enable
    a_r6_irq_follow: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pe_o && pe_ie_i));

endmodule

bind uart_rx_parity uart_rx_parity_checks #(.FRAME_MAX_BITS(FRAME_MAX_BITS)) u_checks (
    .clk         (clk),
    .rst         (rst),
    .len9_i      (len9_i),
    .par_en_i    (par_en_i),
    .addr_wake_i (addr_wake_i),
    .data_acc_i  (data_acc_i),
    .pe_ie_i     (pe_ie_i),
    .rx_data_o   (rx_data_o),
    .rx_valid_o  (rx_valid_o),
    .pe_o        (pe_o),
    .irq_o       (irq_o)
);

// File: tb/uart_rx_parity_tb_top.sv
module uart_rx_parity_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic       len9 = 1'b0, par_en = 1'b0, par_odd = 1'b0, addr_wake = 1'b0;
    logic       mute_req = 1'b0, stat_rd = 1'b0, data_acc = 1'b0, pe_ie = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid, pe, irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int vcount = 0;
    logic [8:0] last_data = '0;
    bit done_flag = 0;

    uart_rx_parity dut_i (
        .clk(clk), .rst(rst), .rx_i(rx), .tick16_i(tick), .len9_i(len9),
        .par_en_i(par_en), .par_odd_i(par_odd), .addr_wake_i(addr_wake),
        .mute_req_i(mute_req), .stat_rd_i(stat_rd), .data_acc_i(data_acc),
        .pe_ie_i(pe_ie), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
        .pe_o(pe), .irq_o(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // tick generator
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick <= (tdiv == 0);
    end

    // ---------------- behavioural reference model ----------------
    bit   m_busy = 0;
    int   m_k = 0;
    int   m_nbits = 8;
    logic [8:0] m_bits = '0;
    bit   m_done = 0;
    bit   e_valid = 0;
    logic [8:0] e_data = '0;
    bit   e_pe = 0;
    bit   m_armed = 0;
    bit   m_muted = 0;

    task automatic model_step();
        int ones, nb, ppos, apos;
        bit perr, addr, setpe, deliver;
        logic [8:0] d;
        setpe = 0;
        e_valid = 0;
        if (m_done) begin
            nb = len9 ? 9 : 8;
            ones = 0;
            for (int i = 0; i < nb; i++) ones += m_bits[i];
            perr = par_odd ? (ones % 2 == 0) : (ones % 2 == 1);
            ppos = nb - 1;
            apos = par_en ? nb - 2 : nb - 1;
            addr = addr_wake && m_bits[apos];
            d = '0;
            for (int i = 0; i < nb; i++)
                if (!(par_en && i == ppos)) d[i] = m_bits[i];
            deliver = !m_muted || addr;
            if (deliver) begin e_valid = 1; e_data = d; end
            if (!m_muted && par_en && perr && !addr) setpe = 1;
            if (m_muted && addr) m_muted = 0;
        end
        if (mute_req && addr_wake) m_muted = 1;
        if (setpe) begin
            e_pe = 1; m_armed = 0;
        end else begin
            if (data_acc) begin
                if (m_armed) e_pe = 0;
                m_armed = 0;
            end
            if (stat_rd) m_armed = 1;
        end
        m_done = 0;
        if (tick) begin
            if (!m_busy) begin
                if (!rx) begin m_busy = 1; m_k = 0; m_nbits = len9 ? 9 : 8; end
            end else begin
                m_k++;
                if (m_k % 16 == 7) begin
                    if (m_k / 16 == 0) begin
                        if (rx) m_busy = 0;
                    end else if (m_k / 16 <= m_nbits) begin
                        if (m_k / 16 == 1) m_bits = '0;
                        m_bits[m_k / 16 - 1] = rx;
                    end else begin
                        m_busy = 0; m_done = 1;
                    end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_done = 0; e_valid = 0; e_data = '0; e_pe = 0;
            m_armed = 0; m_muted = 0;
        end else begin
            model_step();
        end
        #(CLK_PERIOD / 4);
        if (!rst && !done_flag) begin
            total++;
            if (rx_valid !== e_valid || (e_valid && rx_data !== e_data)) begin
                bad++;
                $display("FAIL R2 model compare: valid=%0b data=%h expected valid=%0b data=%h",
                         rx_valid, rx_data, e_valid, e_data);
            end
            if (pe !== e_pe || irq !== (e_pe && pe_ie)) begin
                bad++;
                $display("FAIL R6 model compare: pe=%0b irq=%0b expected pe=%0b irq=%0b",
                         pe, irq, e_pe, e_pe && pe_ie);
            end
            if (rx_valid) begin vcount++; last_data = rx_data; end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [8:0] v);
        int n;
        n = len9 ? 9 : 8;
        rx = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rx = v[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rx = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
    endtask

    task automatic pulse_rd();
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_acc();
        data_acc = 1'b1; @(negedge clk); data_acc = 1'b0; @(negedge clk);
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        while (cycles < WATCHDOG) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
        finish_run();
    end

    initial begin
        int vc;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 data after reset", rx_data, 9'h000);
        check("R1 valid after reset", {8'd0, rx_valid}, 9'h000);
        check("R1 pe after reset", {8'd0, pe}, 9'h000);
        check("R1 irq after reset", {8'd0, irq}, 9'h000);

        // R2: 8-bit, no parity
        vc = vcount; send(9'h0A5);
        check("R2 8-bit count", 9'(vcount - vc), 9'd1);
        check("R2 8-bit data", last_data, 9'h0A5);
        // R2: 9-bit, no parity
        len9 = 1; vc = vcount; send(9'h1C3);
        check("R2 9-bit data", last_data, 9'h1C3);
        check("R5 no parity no error", {8'd0, pe}, 9'h000);
        len9 = 0;

        // R3: glitch on start
        vc = vcount;
        rx = 1'b0; repeat (2 * TICK_DIV) @(negedge clk); rx = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        check("R3 glitch rejected", 9'(vcount - vc), 9'd0);
        send(9'h05A);
        check("R3 frame after glitch", last_data, 9'h05A);

        // R4/R5: even parity, 8-bit
        par_en = 1; pe_ie = 1;
        send(9'h035);
        check("R4 even good", {8'd0, pe}, 9'h000);
        send(9'h0B5);
        check("R4 even bad", {8'd0, pe}, 9'h001);
        check("R5 parity masked", last_data, 9'h035);
        check("R6 irq on", {8'd0, irq}, 9'h001);
        pe_ie = 0; @(negedge clk);
        check("R6 irq off when disabled", {8'd0, irq}, 9'h000);
        send(9'h035);
        check("R6 sticky after good frame", {8'd0, pe}, 9'h001);

        // R7: clear sequence
        pulse_acc();
        check("R7 access alone keeps flag", {8'd0, pe}, 9'h001);
        pulse_rd(); repeat (5) @(negedge clk); pulse_acc();
        check("R7 read then access clears", {8'd0, pe}, 9'h000);

        // R4: odd parity, 9-bit
        len9 = 1; par_odd = 1;
        send(9'h135);
        check("R4 odd good", {8'd0, pe}, 9'h000);
        check("R5 9-bit masked", last_data, 9'h035);
        send(9'h035);
        check("R4 odd bad", {8'd0, pe}, 9'h001);
        pulse_rd(); pulse_acc();
        check("R7 clear again", {8'd0, pe}, 9'h000);

        // R8: pending read cancelled by new error
        pulse_rd();
        send(9'h035);
        check("R8 new error set", {8'd0, pe}, 9'h001);
        pulse_acc();
        check("R8 stale read does not clear", {8'd0, pe}, 9'h001);
        stat_rd = 1; data_acc = 1; @(negedge clk); stat_rd = 0; data_acc = 0; @(negedge clk);
        check("R7 same-cycle arms only", {8'd0, pe}, 9'h001);
        pulse_acc();
        check("R7 access after same-cycle pair clears", {8'd0, pe}, 9'h000);

        // R9: address exempt, 8-bit even parity, address bit = bit 6
        len9 = 0; par_odd = 0; addr_wake = 1;
        send(9'h040);
        check("R9 address no error", {8'd0, pe}, 9'h000);
        check("R9 address delivered", last_data, 9'h040);

        // R10: mute and wake
        mute_req = 1; @(negedge clk); mute_req = 0; @(negedge clk);
        vc = vcount;
        send(9'h005);
        send(9'h001);
        check("R10 muted drops data", 9'(vcount - vc), 9'd0);
        check("R10 muted no error", {8'd0, pe}, 9'h000);
        send(9'h041);
        check("R10 wake on address", 9'(vcount - vc), 9'd1);
        check("R10 wake data", last_data, 9'h041);
        send(9'h003);
        check("R10 awake delivers", last_data, 9'h003);
        send(9'h001);
        check("R10 awake checks parity", {8'd0, pe}, 9'h001);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule